// File: doc/BRIEF.md
# Pipelined Read Output Stage with Selectable Deselect Latency

This block is the data-output end of a synchronous burst SRAM. The address sequencer delivers one registered command per clock: idle/deselect, read or write. The array returns read data in the cycle after a read command is captured. The block registers that data and drives it on a 36-bit bus, together with a single drive-enable that controls the bus tri-state buffers.

The number of cycles the drivers stay on after a deselect can be chosen. In single-cycle mode, turn-off comes one stage earlier than read data. In dual-cycle mode, turn-off takes as long as a read. An asynchronous active-low output enable can cut the drivers at any moment. A sleep input quiets the whole stage two clocks after it rises. When sleep ends, a recovery window of a parameterized number of cycles follows. Inside that window, writes are refused and flagged.

Top module: `srdq_top`

## Requirements
- R1: The command encoding on `cmdIn` is 2'b00 idle/deselect, 2'b01 read, 2'b10 write; 2'b11 is treated as idle. A read captured at edge k has `rdData` sampled at edge k+1, and that word appears on `dqOut` after edge k+1.
- R2: With `oneCycleOff`=1 (single-cycle), `dqDrive` is high only while the output stage holds a read and the input stage also holds a read. A deselect or write captured at an edge turns the drivers off right after that edge.
- R3: With `oneCycleOff`=0 (dual-cycle), a deselect captured at edge k+1 behind a read captured at edge k leaves the drivers on until edge k+2. The drivers are off after edge k+2.
- R4: A write never drives the bus. In either mode, the drivers are off in the cycle after a write is captured, and in the cycle after that.
- R5: While `oeN` is high, `dqDrive` is low at once, with no clock edge needed. Lowering `oeN` re-enables the drivers only when the pipeline holds a read.
- R6: When `sleepIn` is sampled high at edge k and stays high, `dqDrive` is low from edge k+1 on. While asleep, commands are ignored: reads issued during sleep never reach the bus after wake-up.
- R7: After sleep ends (`sleepIn` sampled low at edge j), commands from edge j+2 through edge j+1+RECOVER_CYC are in recovery. A write in this window is dropped, acting as a deselect, and `wrDropErr` is high for the single cycle after it. Reads are accepted as usual. Once the window ends, writes are accepted with no flag.
- R8: An active-low reset (`rstN`) clears the pipeline to deselect at once, with `dqDrive` and `wrDropErr` low.
- R9: Back-to-back reads stream one new word per cycle on `dqOut`, in command order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdIn | input | 2 | Registered command from the address sequencer |
| rdData | input | 36 | Array read data, valid the cycle after a read is captured |
| oneCycleOff | input | 1 | 1 = single-cycle deselect, 0 = dual-cycle deselect |
| oeN | input | 1 | Asynchronous output enable, active low |
| sleepIn | input | 1 | Sleep request, active high |
| dqOut | output | 36 | Output data word, meaningful while dqDrive is high |
| dqDrive | output | 1 | Tri-state drive enable for all four byte lanes |
| wrDropErr | output | 1 | One-cycle pulse: a write was refused during recovery |

## Verification
The interesting collision is a write that is refused during post-sleep recovery while, in dual-cycle mode, a read is still being held on the bus. In that case the drop and the deselect hold occur in the same cycle. The bench wakes the block and issues a read followed at once by a write inside the window. It then expects `wrDropErr` high together with `dqDrive` still on and carrying the read word. An accepted write would have cut the drivers. A later write placed just past the window must leave the flag low and turn the drivers off. This checks both ends of the recovery count.

// File: rtl/srdq_pkg.sv
package srdq_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_RSVD  = 2'b11
  } cmdE;

  // strobes from control to datapath
  typedef struct packed {
    logic loadData;
    logic driveReq;
  } strobeT;

endpackage

// File: rtl/srdq_ctrl.sv
module srdq_ctrl
  import srdq_pkg::*;
#(
  parameter int RECOVER_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] cmdIn,
  input  logic       oneCycleOff,
  input  logic       sleepIn,
  output strobeT     strb,
  output logic       wrDropErr
);

  localparam int REC_W = (RECOVER_CYC < 1) ? 1 : $clog2(RECOVER_CYC + 1);

  cmdE cmdRaw;
  cmdE effCmd;
  cmdE stage1;
  cmdE stage2;
  logic sleepArm;
  logic asleep;
  logic [REC_W-1:0] recCnt;
  logic inRecovery;

  assign cmdRaw     = cmdE'(cmdIn);
  assign inRecovery = (recCnt != '0);

  // command actually entering the pipeline
  always_comb begin
    if (asleep)                                     effCmd = CMD_IDLE;
    else if (cmdRaw == CMD_WRITE && inRecovery)     effCmd = CMD_IDLE;
    else if (cmdRaw == CMD_RSVD)                    effCmd = CMD_IDLE;
    else                                            effCmd = cmdRaw;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1    <= CMD_IDLE;
      stage2    <= CMD_IDLE;
      sleepArm  <= 1'b0;
      asleep    <= 1'b0;
      recCnt    <= '0;
      wrDropErr <= 1'b0;
    end else begin
      stage1    <= effCmd;
      stage2    <= stage1;
      sleepArm  <= sleepIn;
      asleep    <= sleepArm;
      if (asleep && !sleepArm)
        recCnt <= REC_W'(RECOVER_CYC);
      else if (inRecovery)
        recCnt <= recCnt - 1'b1;
      wrDropErr <= !asleep && inRecovery && (cmdRaw == CMD_WRITE);
    end
  end

  // drive-enable: mode picks how early a non-read in the input stage cuts drivers
  always_comb begin
    strb.loadData = (stage1 == CMD_READ) && !asleep;
    strb.driveReq = !asleep && (stage2 == CMD_READ) &&
                    (oneCycleOff ? (stage1 == CMD_READ) : (stage1 != CMD_WRITE));
  end

  p_write_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (effCmd == CMD_WRITE) |=> !strb.driveReq);

  p_scd_cut_r2: assert property (@(posedge clk) disable iff (!rstN)
    (oneCycleOff && effCmd != CMD_READ) |=> (!oneCycleOff || !strb.driveReq));

  p_dcd_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!oneCycleOff && stage1 == CMD_READ && effCmd == CMD_IDLE && !asleep && !sleepArm)
      |=> (oneCycleOff || strb.driveReq));

  p_err_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrDropErr |-> $past(cmdRaw == CMD_WRITE));

  p_rec_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    recCnt <= REC_W'(RECOVER_CYC));

endmodule

// File: rtl/srdq_data.sv
module srdq_data
  import srdq_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] dqOut
);

  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dataQ <= '0;
    else if (strb.loadData) dataQ <= rdData;
  end

  assign dqOut = dataQ;

  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadData |=> $stable(dataQ));

  p_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadData |=> (dataQ == $past(rdData)));

endmodule

// File: rtl/srdq_top.sv
module srdq_top
  import srdq_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int RECOVER_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cmdIn,
  input  logic [DATA_W-1:0] rdData,
  input  logic              oneCycleOff,
  input  logic              oeN,
  input  logic              sleepIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqDrive,
  output logic              wrDropErr
);

  strobeT strb;

  srdq_ctrl #(.RECOVER_CYC(RECOVER_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdIn(cmdIn), .oneCycleOff(oneCycleOff),
    .sleepIn(sleepIn), .strb(strb), .wrDropErr(wrDropErr)
  );

  srdq_data #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .rdData(rdData), .dqOut(dqOut)
  );

  // asynchronous gate: output enable can only remove drive
  assign dqDrive = strb.driveReq && !oeN;

  p_sleep_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(sleepIn, 2) && $past(rstN, 2) && $past(rstN)) |-> !dqDrive);

  p_reset_quiet_r8: assert property (@(posedge clk)
    !rstN |-> (!dqDrive && !wrDropErr));

endmodule

// File: tb/srdq_top_bench.sv
module srdq_top_bench;

  localparam logic [1:0] IDLE = 2'b00;
  localparam logic [1:0] RD   = 2'b01;
  localparam logic [1:0] WR   = 2'b10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  cmdIn;
  logic [35:0] rdData;
  logic        oneCycleOff;
  logic        oeN;
  logic        sleepIn;
  logic [35:0] dqOut;
  logic        dqDrive;
  logic        wrDropErr;

  int nCmp = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  srdq_top u_srdq_top (
    .clk(clk), .rstN(rstN), .cmdIn(cmdIn), .rdData(rdData),
    .oneCycleOff(oneCycleOff), .oeN(oeN), .sleepIn(sleepIn),
    .dqOut(dqOut), .dqDrive(dqDrive), .wrDropErr(wrDropErr)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic drain;
    cmdIn = IDLE;
    repeat (3) tick();
  endtask

  task automatic t_reset;
    rstN = 1'b0; cmdIn = IDLE; rdData = '0; oneCycleOff = 1'b1; oeN = 1'b0; sleepIn = 1'b0;
    repeat (2) tick();
    chk("R8 drive in reset", {35'd0, dqDrive}, 36'd0);
    chk("R8 err in reset", {35'd0, wrDropErr}, 36'd0);
    rstN = 1'b1;
    tick();
    chk("R8 drive after reset", {35'd0, dqDrive}, 36'd0);
  endtask

  task automatic t_scd_burst;
    oneCycleOff = 1'b1; cmdIn = RD; tick();
    chk("R1 scd no drive yet", {35'd0, dqDrive}, 36'd0);
    rdData = 36'hA_0000_0001; cmdIn = RD; tick();
    chk("R9 scd drive 1st", {35'd0, dqDrive}, 36'd1);
    chk("R1 scd data 1st", dqOut, 36'hA_0000_0001);
    rdData = 36'hA_0000_0002; cmdIn = RD; tick();
    chk("R9 scd data 2nd", dqOut, 36'hA_0000_0002);
    rdData = 36'hA_0000_0003; cmdIn = IDLE; tick();
    chk("R2 scd cut on deselect", {35'd0, dqDrive}, 36'd0);
    tick();
    chk("R2 scd stays off", {35'd0, dqDrive}, 36'd0);
    drain();
  endtask

  task automatic t_dcd_burst;
    oneCycleOff = 1'b0; cmdIn = RD; tick();
    rdData = 36'hB_0000_0011; tick();
    chk("R9 dcd data 1st", dqOut, 36'hB_0000_0011);
    rdData = 36'hB_0000_0012; tick();
    chk("R9 dcd data 2nd", dqOut, 36'hB_0000_0012);
    rdData = 36'hB_0000_0013; cmdIn = IDLE; tick();
    chk("R3 dcd hold drive", {35'd0, dqDrive}, 36'd1);
    chk("R3 dcd hold data", dqOut, 36'hB_0000_0013);
    tick();
    chk("R3 dcd off 2nd edge", {35'd0, dqDrive}, 36'd0);
    drain();
  endtask

  task automatic t_write_cut;
    oneCycleOff = 1'b0; cmdIn = RD; tick();
    rdData = 36'hC_0000_0021; tick();
    chk("R4 read before write", {35'd0, dqDrive}, 36'd1);
    cmdIn = WR; tick();
    chk("R4 dcd write cuts", {35'd0, dqDrive}, 36'd0);
    tick();
    chk("R4 write in output stage", {35'd0, dqDrive}, 36'd0);
    cmdIn = 2'b11; tick(); tick();
    chk("R1 reserved code idle", {35'd0, dqDrive}, 36'd0);
    drain();
  endtask

  task automatic t_oe;
    oneCycleOff = 1'b0; oeN = 1'b0; cmdIn = RD; tick();
    rdData = 36'hD_0000_0031; tick();
    chk("R5 on before oe", {35'd0, dqDrive}, 36'd1);
    oeN = 1'b1; #1;
    chk("R5 oe high cuts async", {35'd0, dqDrive}, 36'd0);
    oeN = 1'b0; #1;
    chk("R5 oe low restores", {35'd0, dqDrive}, 36'd1);
    drain();
    oeN = 1'b1; #1; oeN = 1'b0; #1;
    chk("R5 oe low no read", {35'd0, dqDrive}, 36'd0);
  endtask

  task automatic t_sleep_recover;
    oneCycleOff = 1'b0; cmdIn = RD; rdData = 36'hE_0000_0041; tick();
    tick();
    chk("R6 drive before sleep", {35'd0, dqDrive}, 36'd1);
    sleepIn = 1'b1; tick();
    chk("R6 still on 1 edge", {35'd0, dqDrive}, 36'd1);
    tick();
    chk("R6 asleep off", {35'd0, dqDrive}, 36'd0);
    repeat (3) begin
      tick();
      chk("R6 asleep stays off", {35'd0, dqDrive}, 36'd0);
    end
    sleepIn = 1'b0; tick();
    chk("R6 waking off", {35'd0, dqDrive}, 36'd0);
    cmdIn = IDLE; tick();
    chk("R6 sleep reads ignored", {35'd0, dqDrive}, 36'd0);
    cmdIn = WR; tick();
    chk("R7 drop flag", {35'd0, wrDropErr}, 36'd1);
    cmdIn = RD; tick();
    chk("R7 flag one cycle", {35'd0, wrDropErr}, 36'd0);
    rdData = 36'hE_0000_0042; cmdIn = WR; tick();
    chk("R7 drop flag with read", {35'd0, wrDropErr}, 36'd1);
    chk("R7 dropped write no cut", {35'd0, dqDrive}, 36'd1);
    chk("R7 read data in recovery", dqOut, 36'hE_0000_0042);
    cmdIn = RD; tick();
    chk("R7 off after hold", {35'd0, dqDrive}, 36'd0);
    rdData = 36'hE_0000_0043; cmdIn = WR; tick();
    chk("R7 window over no flag", {35'd0, wrDropErr}, 36'd0);
    chk("R7 accepted write cuts", {35'd0, dqDrive}, 36'd0);
    drain();
  endtask

  task automatic t_mid_reset;
    oneCycleOff = 1'b0; cmdIn = RD; tick();
    rdData = 36'hF_0000_0051; tick();
    chk("R8 on before reset", {35'd0, dqDrive}, 36'd1);
    rstN = 1'b0; #1;
    chk("R8 async reset cuts", {35'd0, dqDrive}, 36'd0);
    cmdIn = IDLE; tick();
    rstN = 1'b1; tick();
    chk("R8 idle after reset", {35'd0, dqDrive}, 36'd0);
  endtask

  initial begin
    t_reset();
    t_scd_burst();
    t_dcd_burst();
    t_write_cut();
    t_oe();
    t_sleep_recover();
    t_mid_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #100000;
    nCmp++;
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule